// File: doc/BRIEF.md
# Block-Parallel Adler-32 Checksum Engine

This engine computes an Adler-32 checksum over a byte stream. Each accepted beat carries up to `LANES` bytes, and each beat updates two wide running sums in one cycle. The running sum `A` is the plain sum of the bytes plus its start value. The running sum `B` accumulates the successive values of `A`. For a beat of N bytes, the engine uses the closed form of that accumulation, which weights every byte by its distance from the end of the beat. This gives the same result as a byte-serial loop without looping.

Neither sum is reduced after every beat. A counter tracks the bytes absorbed since the last reduction. Once the count gets close to the limit that still fits in 32 bits, the engine spends one cycle reducing both sums modulo 65521, and it holds off input during that cycle. The final reduction is done only when the message ends. That reduction is done by a separate fold-based remainder unit. A caller can load a seed to continue a running checksum. If no seed is loaded, every message starts from A=1, B=0.

Top module: `adler_engine`

## Requirements
- R1: After reset the engine sets `in_ready` high, `sum_done` low and `sum_out` to 0.
- R2: A beat with `in_cnt` equal to `LANES` absorbs bytes x[0..N-1], where byte i sits at `in_data[8i+7:8i]`. The update is A += sum of x[i] and B += N*A_old + sum of (N-i)*x[i], so the first byte has weight N.
- R3: A beat with `in_cnt` = n, for n from 1 to `LANES`-1, applies the R2 rule with N = n and ignores lanes n and above. With n = 1 this is the single-byte rule: A += x, then B += A.
- R4: For any message length, `sum_out` equals {B mod 65521, A mod 65521}, with B in bits 31:16 and A in bits 15:0. This is the value a byte-serial reference gives when it reduces after every byte.
- R5: After a beat that does not end the message, the engine checks the bytes absorbed since the last reduction. If they exceed `MAX_RUN`-`LANES`, it drops `in_ready` for exactly one cycle and writes back both sums reduced. No more than `MAX_RUN` bytes are ever unreduced, with a default of 5552.
- R6: The cycle after the beat with `in_last` set is accepted, the engine performs the final reduction. `sum_done` is high for exactly one cycle, in the next cycle. `sum_out` holds its value until the next `sum_done`.
- R7: A beat with `in_cnt` = 0 and `in_last` set ends an empty message. In that case `sum_out` equals the start value unreduced: 0x00000001 by default, or the loaded seed.
- R8: `seed_load` in the accepting state loads A = `seed_val[15:0]` and B = `seed_val[31:16]`, and `in_ready` is low in that cycle. Each seed half must be below 65521.
- R9: After `sum_done`, the sums return to A=1, B=0. A message sent without a seed therefore yields the standard checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load the start value from seed_val |
| seed_val | input | 32 | Start value, B in 31:16, A in 15:0 |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_data | input | LANES*8 | Beat bytes, byte 0 in the low lane |
| in_cnt | input | $clog2(LANES+1) | Number of valid bytes in the beat |
| in_last | input | 1 | Beat ends the message |
| sum_out | output | 32 | Checksum of the last finished message |
| sum_done | output | 1 | One-cycle strobe when sum_out updates |

## Verification
The bench builds the engine with its defaults, `LANES`=16 and `MAX_RUN`=5552. With these values a few hundred beats reach the reduction point exactly at 5552 bytes. The sweep covers every length from 0 to 40, both with tails sent as single bytes and with tails sent as one partial beat. The long messages include all-0xFF runs of 5553 and 11105 bytes, which drive the unreduced sums to their largest values. For these, the bench compares the number of stalled cycles against the count predicted from the message length.

// File: rtl/adler_pkg.sv
package adler_pkg;
  localparam int unsigned ADLER_MOD = 65521;

  // 2^16 is congruent to 15 modulo 65521, so two folds and one subtract give the remainder.
  function automatic logic [15:0] fold_mod(input logic [31:0] x);
    logic [20:0] s1;
    logic [16:0] s2;
    s1 = 21'(x[31:16]) * 21'd15 + 21'(x[15:0]);
    s2 = 17'(s1[20:16]) * 17'd15 + 17'(s1[15:0]);
    if (s2 >= 17'(ADLER_MOD)) s2 = s2 - 17'(ADLER_MOD);
    return s2[15:0];
  endfunction
endpackage

// File: rtl/adler_mod.sv
module adler_mod (
  input  logic [31:0] val,
  output logic [15:0] rem
);
  import adler_pkg::*;
  assign rem = fold_mod(val);
endmodule

// File: rtl/adler_blk.sv
module adler_blk #(
  parameter int LANES = 16,
  parameter int NW    = $clog2(LANES + 1)
) (
  input  logic [31:0]        a_in,
  input  logic [31:0]        b_in,
  input  logic [LANES*8-1:0] data,
  input  logic [NW-1:0]      n,
  output logic [31:0]        a_out,
  output logic [31:0]        b_out
);
  localparam int PW = 8 + NW;   // one weighted product
  localparam int SW = PW + NW;  // sum of all lanes

  // weight of lane i within a beat of n bytes: n-i for live lanes, 0 beyond
  function automatic logic [NW-1:0] lane_weight(input logic [NW-1:0] cnt, input int idx);
    return (cnt > NW'(idx)) ? cnt - NW'(idx) : '0;
  endfunction

  logic [PW-1:0] wprod [LANES];
  logic [PW-1:0] plain [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NW-1:0] w;
    assign w        = lane_weight(n, g);
    assign wprod[g] = PW'(data[8*g +: 8]) * PW'(w);
    assign plain[g] = (w != '0) ? PW'(data[8*g +: 8]) : '0;
  end

  logic [SW-1:0] wsum, psum;
  always_comb begin
    wsum = '0;
    psum = '0;
    for (int i = 0; i < LANES; i++) begin
      wsum = wsum + SW'(wprod[i]);
      psum = psum + SW'(plain[i]);
    end
  end

  assign a_out = a_in + 32'(psum);
  assign b_out = b_in + 32'(n) * a_in + 32'(wsum);
endmodule

// File: rtl/adler_engine.sv
module adler_engine #(
  parameter int LANES   = 16,
  parameter int MAX_RUN = 5552
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         seed_load,
  input  logic [31:0]                  seed_val,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*8-1:0]           in_data,
  input  logic [$clog2(LANES+1)-1:0]   in_cnt,
  input  logic                         in_last,
  output logic [31:0]                  sum_out,
  output logic                         sum_done
);
  localparam int NW     = $clog2(LANES + 1);
  localparam int CW     = $clog2(MAX_RUN + LANES + 1);
  localparam int RED_AT = MAX_RUN - LANES;

  typedef enum logic [1:0] {ST_RUN, ST_RED, ST_FIN} st_t;
  st_t state;

  logic [31:0]   acc_a, acc_b, nxt_a, nxt_b;
  logic [15:0]   red_a, red_b;
  logic [CW-1:0] run_cnt, cnt_next;
  logic [NW-1:0] eff_n;
  logic          any_bytes, take;
  logic          red_fire, fin_fire;

  assign in_ready = (state == ST_RUN) && !seed_load;
  assign take     = in_valid && in_ready;
  assign eff_n    = (in_cnt > NW'(LANES)) ? NW'(LANES) : in_cnt;
  assign cnt_next = run_cnt + CW'(eff_n);
  assign red_fire = (state == ST_RED);
  assign fin_fire = (state == ST_FIN);

  adler_blk #(.LANES(LANES), .NW(NW)) u_blk (
    .a_in(acc_a), .b_in(acc_b), .data(in_data), .n(eff_n),
    .a_out(nxt_a), .b_out(nxt_b)
  );

  adler_mod u_mod_a (.val(acc_a), .rem(red_a));
  adler_mod u_mod_b (.val(acc_b), .rem(red_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      acc_a     <= 32'd1;
      acc_b     <= 32'd0;
      run_cnt   <= '0;
      any_bytes <= 1'b0;
      sum_out   <= '0;
      sum_done  <= 1'b0;
    end else begin
      sum_done <= 1'b0;
      case (state)
        ST_RUN: begin
          if (seed_load) begin
            acc_a <= {16'd0, seed_val[15:0]};
            acc_b <= {16'd0, seed_val[31:16]};
          end else if (take) begin
            acc_a     <= nxt_a;
            acc_b     <= nxt_b;
            run_cnt   <= cnt_next;
            any_bytes <= any_bytes || (eff_n != '0);
            if (in_last)                       state <= ST_FIN;
            else if (cnt_next > CW'(RED_AT))   state <= ST_RED;
          end
        end
        ST_RED: begin
          acc_a   <= {16'd0, red_a};
          acc_b   <= {16'd0, red_b};
          run_cnt <= '0;
          state   <= ST_RUN;
        end
        default: begin
          sum_out   <= any_bytes ? {red_b, red_a} : {acc_b[15:0], acc_a[15:0]};
          sum_done  <= 1'b1;
          acc_a     <= 32'd1;
          acc_b     <= 32'd0;
          run_cnt   <= '0;
          any_bytes <= 1'b0;
          state     <= ST_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/adler_engine_chk.sv
module adler_engine_chk #(
  parameter int MAX_RUN = 5552,
  parameter int CW      = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          sum_done,
  input logic          red_fire,
  input logic          fin_fire,
  input logic [CW-1:0] run_cnt,
  input logic [31:0]   acc_a,
  input logic [31:0]   acc_b
);
  assert_stall_on_reduce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    red_fire |-> !in_ready);

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(MAX_RUN));

  assert_reduced_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    red_fire |=> (acc_a < 32'd65521) && (acc_b < 32'd65521));

  assert_done_follows_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fire |=> sum_done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_done |=> !sum_done);

  assert_restart_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sum_done |-> (acc_a == 32'd1) && (acc_b == 32'd0));
endmodule

bind adler_engine adler_engine_chk #(.MAX_RUN(MAX_RUN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .sum_done(sum_done),
  .red_fire(red_fire), .fin_fire(fin_fire), .run_cnt(run_cnt),
  .acc_a(acc_a), .acc_b(acc_b)
);

// File: tb/tb_adler_engine.sv
module tb_adler_engine;
  localparam int LANES = 16;
  localparam int NW    = $clog2(LANES + 1);

  logic clk = 0, rst_n = 0;
  logic seed_load = 0;
  logic [31:0] seed_val = '0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [LANES*8-1:0] in_data = '0;
  logic [NW-1:0] in_cnt = '0;
  logic [31:0] sum_out;
  logic sum_done;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  adler_engine #(.LANES(LANES), .MAX_RUN(5552)) dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_cnt(in_cnt), .in_last(in_last), .sum_out(sum_out), .sum_done(sum_done)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] byte_at(input int idx, input int salt, input int fill);
    if (fill != 0) return 8'hFF;
    return 8'((idx * 37 + salt * 101 + (idx >> 4) * 5) ^ (salt * 7 + idx * idx));
  endfunction

  // part=0: tail sent one byte per beat; part=1: tail sent as one partial beat
  task automatic run_msg(input int len, input int salt, input int fill, input int part,
                         input logic use_seed, input logic [31:0] seed,
                         output logic [31:0] got, output logic [31:0] exp_v,
                         output int stall_n, output int wait_n);
    int unsigned ra, rb;
    int pos;
    ra = use_seed ? int'(seed[15:0]) : 1;
    rb = use_seed ? int'(seed[31:16]) : 0;
    for (int i = 0; i < len; i++) begin
      ra = (ra + byte_at(i, salt, fill)) % 65521;
      rb = (rb + ra) % 65521;
    end
    exp_v = {rb[15:0], ra[15:0]};
    stall_n = 0;
    if (use_seed) begin
      @(negedge clk);
      seed_load = 1; seed_val = seed;
      #1 chk(in_ready == 1'b0, "R8 ready low on seed", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      seed_load = 0;
    end
    pos = 0;
    do begin
      int n;
      n = (len - pos >= LANES) ? LANES : ((part != 0) ? len - pos : (len - pos > 0 ? 1 : 0));
      @(negedge clk);
      in_valid = 1;
      in_cnt   = NW'(n);
      in_last  = (pos + n == len);
      in_data  = '0;
      for (int k = 0; k < n; k++) in_data[8*k +: 8] = byte_at(pos + k, salt, fill);
      while (!in_ready) begin
        stall_n++;
        @(negedge clk);
      end
      @(posedge clk);
      pos += n;
    end while (pos < len);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    wait_n = 1;
    while (!sum_done && wait_n < 50) begin
      @(negedge clk);
      wait_n++;
    end
    got = sum_out;
    @(negedge clk);
    chk(sum_done == 1'b0, "R6 done one cycle", {31'd0, sum_done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got, exp_v, first;
    int st, wt;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
    chk(sum_done == 1'b0, "R1 done", {31'd0, sum_done}, 32'd0);
    chk(sum_out == 32'd0, "R1 result", sum_out, 32'd0);
    rst_n = 1;

    // R7 empty messages
    run_msg(0, 1, 0, 0, 1'b0, '0, got, exp_v, st, wt);
    chk(got == 32'h0000_0001, "R7 empty default", got, 32'h0000_0001);
    run_msg(0, 1, 0, 0, 1'b1, 32'h1234_5678, got, exp_v, st, wt);
    chk(got == 32'h1234_5678, "R7 empty seeded", got, 32'h1234_5678);

    // sweep of short lengths, both tail styles (R2 full beats, R3 partial/single, R4 general)
    for (int part = 0; part < 2; part++) begin
      for (int len = 1; len <= 40; len++) begin
        run_msg(len, len + part * 50, 0, part, 1'b0, '0, got, exp_v, st, wt);
        if (len % LANES == 0)  chk(got == exp_v, "R2 full beats", got, exp_v);
        else if (part == 1)    chk(got == exp_v, "R3 partial beat", got, exp_v);
        else                   chk(got == exp_v, "R4 single tail", got, exp_v);
        chk(wt == 2, "R6 done timing", wt, 2);
      end
    end

    // R8 continuation and R9 restart to default afterwards
    run_msg(100, 9, 0, 0, 1'b0, '0, first, exp_v, st, wt);
    chk(first == exp_v, "R4 first part", first, exp_v);
    run_msg(77, 13, 0, 1, 1'b1, first, got, exp_v, st, wt);
    chk(got == exp_v, "R8 seeded continuation", got, exp_v);
    run_msg(33, 4, 0, 0, 1'b0, '0, got, exp_v, st, wt);
    chk(got == exp_v, "R9 default after done", got, exp_v);

    // R5 reduction boundary
    run_msg(5536, 21, 0, 0, 1'b0, '0, got, exp_v, st, wt);
    chk(got == exp_v, "R4 len 5536", got, exp_v);
    chk(st == 0, "R5 no stall 5536", st, 0);
    run_msg(5552, 22, 0, 0, 1'b0, '0, got, exp_v, st, wt);
    chk(got == exp_v, "R4 len 5552", got, exp_v);
    chk(st == 0, "R5 no stall 5552", st, 0);
    run_msg(5553, 23, 0, 0, 1'b0, '0, got, exp_v, st, wt);
    chk(got == exp_v, "R5 len 5553", got, exp_v);
    chk(st == 1, "R5 one stall 5553", st, 1);
    run_msg(5553, 0, 1, 1, 1'b1, 32'hFFF0_FFF0, got, exp_v, st, wt);
    chk(got == exp_v, "R5 all ones 5553 seeded", got, exp_v);
    chk(st == 1, "R5 stall all ones", st, 1);
    run_msg(11105, 0, 1, 0, 1'b0, '0, got, exp_v, st, wt);
    chk(got == exp_v, "R5 all ones 11105", got, exp_v);
    chk(st == 2, "R5 two stalls 11105", st, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule